// File: doc/BRIEF.md
# Set-Associative Cache Tag Controller

This block keeps the tag, valid and dirty state of a set-associative cache. By default it has four ways, sixteen sets and a 16-bit physical address. A request carries an address and an access kind. One cycle after the request is accepted, the block returns an outcome code and the way it used:

- a hit;
- a fill into a way that held nothing;
- an eviction of a clean line;
- an eviction of a dirty line.

The outcome code stands in for the refill and writeback traffic that a full cache would start. There is no data array in this block.

Misses use empty ways before they evict anything. When every way of a set is valid, a tree pseudo-LRU unit inside the block names the victim. Every hit, fill or eviction moves that tree away from the way just used.

Three commands act on the whole array:
- **Invalidate** drops every line.
- **Restart** drops every line and also clears the replacement history, to mark the start of a new run.
- **Flush** walks the sets one per cycle and cleans every line. It then raises a one-cycle done pulse.

Top module: `cache_tag_ctrl`

## Requirements
- R1: With default parameters the tag is address bits [15:8] and the set index is bits [7:4]. Bits [3:0] are the byte offset and have no effect on lookup: 0x123F hits a line filled by 0x1234.
- R2: A request is accepted when req_valid_i and req_ready_o are both high. In the next cycle rsp_valid_o is high with rsp_code_o and rsp_way_o. rsp_code_o is 2'b00 for a hit, 2'b01 for a fill into an invalid way, 2'b10 for a clean eviction and 2'b11 for a dirty eviction. rsp_valid_o is low in every other cycle.
- R3: A miss in a set that has an invalid way fills the lowest-numbered invalid way. Successive new tags in an empty set therefore land in way 0, 1, 2, then 3.
- R4: req_type_i is 2'b00 for read, 2'b01 for write, 2'b10 for atomic and 2'b11 for a reserved kind that acts as a read. Write and atomic leave the line dirty. A read fill leaves it clean. A read hit keeps the dirty bit unchanged.
- R5: A miss in a full set replaces the victim way. The code is 2'b11 if the old line was dirty and 2'b10 otherwise. The new line's dirty bit then follows R4.
- R6: The victim comes from a three-node tree per set; all nodes are 0 after reset or restart. The root picks a half: 0 means ways 0/1, 1 means ways 2/3. The chosen child picks a way: 0 means the lower way, 1 means the upper. Each hit, fill or eviction sets the nodes on the path to the used way so that they point away from it.
- R7: A one-cycle invalidate_i clears every valid bit and leaves the replacement trees unchanged.
- R8: A one-cycle restart_i clears every valid bit and resets every replacement tree to all zeros.
- R9: flush_i clears the dirty bits one set per cycle, starting at set 0, and keeps every line valid. flush_done_o is high for exactly one cycle, NUM_SETS+1 rising edges after the edge that sampled flush_i.
- R10: req_ready_o is low while a flush runs. It is also low in any cycle where flush_i, invalidate_i or restart_i is high.
- R11: After reset all lines are invalid and clean, the trees are all zeros, req_ready_o is high and rsp_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request present |
| req_ready_o | output | 1 | Access can be accepted this cycle |
| req_addr_i | input | ADDR_W | Physical address of the access |
| req_type_i | input | 2 | Access kind: read, write, atomic, reserved |
| invalidate_i | input | 1 | Clear all valid bits |
| restart_i | input | 1 | Clear all valid bits and replacement state |
| flush_i | input | 1 | Start a whole-cache clean |
| flush_done_o | output | 1 | One-cycle pulse at the end of a flush |
| rsp_valid_o | output | 1 | Outcome present |
| rsp_code_o | output | 2 | Outcome code |
| rsp_way_o | output | WAY_W | Way that was hit, filled or replaced |

## Verification
The bench builds the block with its default parameters: a 16-bit address, sixteen sets and four ways. With these values a single set fills and starts evicting after a handful of accesses, so every tree state and every outcome code comes up often. Random tags are drawn from a pool of six, with random sets and offsets, and invalidate, restart and flush commands are mixed in. This keeps hits, fills, clean evictions and dirty evictions all frequent. A full flush of sixteen sets stays short enough to run many times.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;
  typedef enum logic [1:0] {
    RSP_HIT    = 2'b00,
    RSP_FILL   = 2'b01,
    RSP_EVCLN  = 2'b10,
    RSP_EVDRT  = 2'b11
  } rsp_code_e;

  typedef enum logic [1:0] {
    ACC_RD   = 2'b00,
    ACC_WR   = 2'b01,
    ACC_AMO  = 2'b10,
    ACC_RSVD = 2'b11
  } acc_type_e;

  function automatic logic acc_is_store(logic [1:0] t);
    return (t == ACC_WR) || (t == ACC_AMO);
  endfunction
endpackage

// File: rtl/tag_way_bank.sv
module tag_way_bank #(
  parameter int unsigned NUM_SETS = 16,
  parameter int unsigned SET_W    = 4,
  parameter int unsigned TAG_W    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] rd_set_i,
  output logic [TAG_W-1:0] rd_tag_o,
  output logic             rd_valid_o,
  output logic             rd_dirty_o,
  input  logic             wr_en_i,
  input  logic [SET_W-1:0] wr_set_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic             wr_dirty_i,
  input  logic             clr_valid_i,
  input  logic             clr_dirty_en_i,
  input  logic [SET_W-1:0] clr_dirty_set_i
);
  logic [TAG_W-1:0]    tag_q [NUM_SETS];
  logic [NUM_SETS-1:0] valid_q;
  logic [NUM_SETS-1:0] dirty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
      for (int s = 0; s < NUM_SETS; s++) tag_q[s] <= '0;
    end else begin
      if (clr_valid_i)  valid_q <= '0;
      else if (wr_en_i) valid_q[wr_set_i] <= 1'b1;
      if (wr_en_i) begin
        dirty_q[wr_set_i] <= wr_dirty_i;
        tag_q[wr_set_i]   <= wr_tag_i;
      end else if (clr_dirty_en_i) begin
        dirty_q[clr_dirty_set_i] <= 1'b0;
      end
    end
  end

  assign rd_tag_o   = tag_q[rd_set_i];
  assign rd_valid_o = valid_q[rd_set_i];
  assign rd_dirty_o = dirty_q[rd_set_i];
endmodule

// File: rtl/plru_tree.sv
module plru_tree #(
  parameter int unsigned NUM_SETS = 16,
  parameter int unsigned SET_W    = 4,
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned WAY_W    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [SET_W-1:0] rd_set_i,
  output logic [WAY_W-1:0] victim_o,
  input  logic             upd_en_i,
  input  logic [SET_W-1:0] upd_set_i,
  input  logic [WAY_W-1:0] upd_way_i
);
  localparam int unsigned NODES = NUM_WAYS - 1;

  // heap order: node n (1-based) has children 2n and 2n+1, stored at index n-1
  logic [NODES-1:0] bits_q [NUM_SETS];
  logic [NODES-1:0] cur, nxt;
  logic [WAY_W:0]   vnode, unode;
  logic [WAY_W-1:0] vidx, uidx;
  logic             udir;

  assign cur = bits_q[rd_set_i];

  always_comb begin
    vnode = (WAY_W+1)'(1);
    vidx  = '0;
    for (int l = 0; l < WAY_W; l++) begin
      vidx  = vnode[WAY_W-1:0] - WAY_W'(1);
      vnode = {vnode[WAY_W-1:0], cur[vidx]};
    end
  end
  assign victim_o = vnode[WAY_W-1:0];

  always_comb begin
    nxt   = bits_q[upd_set_i];
    unode = (WAY_W+1)'(1);
    uidx  = '0;
    udir  = 1'b0;
    for (int l = 0; l < WAY_W; l++) begin
      udir      = upd_way_i[WAY_W-1-l];
      uidx      = unode[WAY_W-1:0] - WAY_W'(1);
      nxt[uidx] = ~udir;
      unode     = {unode[WAY_W-1:0], udir};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SETS; s++) bits_q[s] <= '0;
    end else if (clr_i) begin
      for (int s = 0; s < NUM_SETS; s++) bits_q[s] <= '0;
    end else if (upd_en_i) begin
      bits_q[upd_set_i] <= nxt;
    end
  end
endmodule

// File: rtl/free_way_pick.sv
module free_way_pick #(
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned WAY_W    = 2
) (
  input  logic [NUM_WAYS-1:0] valid_i,
  output logic                any_free_o,
  output logic [WAY_W-1:0]    free_way_o
);
  always_comb begin
    any_free_o = 1'b0;
    free_way_o = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (!valid_i[w]) begin
        any_free_o = 1'b1;
        free_way_o = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl
  import cache_tag_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned OFFSET_W = 4,
  parameter int unsigned NUM_SETS = 16,
  parameter int unsigned NUM_WAYS = 4,
  localparam int unsigned SET_W   = $clog2(NUM_SETS),
  localparam int unsigned WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_type_i,
  input  logic              invalidate_i,
  input  logic              restart_i,
  input  logic              flush_i,
  output logic              flush_done_o,
  output logic              rsp_valid_o,
  output logic [1:0]        rsp_code_o,
  output logic [WAY_W-1:0]  rsp_way_o
);
  localparam int unsigned TAG_W = ADDR_W - SET_W - OFFSET_W;
  localparam logic [SET_W-1:0] LAST_SET = SET_W'(NUM_SETS - 1);

  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] req_tag;
  logic             acc;
  logic             store;

  logic [TAG_W-1:0]    rd_tag   [NUM_WAYS];
  logic [NUM_WAYS-1:0] rd_valid, rd_dirty, hit_vec, wr_en_vec;

  logic             hit, any_free;
  logic [WAY_W-1:0] hit_way, free_way, victim_way, sel_way;
  logic             wr_dirty;
  rsp_code_e        code;

  logic             flush_busy_q, flush_done_q;
  logic [SET_W-1:0] flush_set_q;

  logic             rsp_valid_q;
  logic [1:0]       rsp_code_q;
  logic [WAY_W-1:0] rsp_way_q;

  assign set_idx     = req_addr_i[OFFSET_W +: SET_W];
  assign req_tag     = req_addr_i[ADDR_W-1 -: TAG_W];
  assign req_ready_o = !flush_busy_q && !flush_i && !invalidate_i && !restart_i;
  assign acc         = req_valid_i && req_ready_o;
  assign store       = acc_is_store(req_type_i);

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    tag_way_bank #(
      .NUM_SETS(NUM_SETS), .SET_W(SET_W), .TAG_W(TAG_W)
    ) u_bank (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .rd_set_i       (set_idx),
      .rd_tag_o       (rd_tag[w]),
      .rd_valid_o     (rd_valid[w]),
      .rd_dirty_o     (rd_dirty[w]),
      .wr_en_i        (wr_en_vec[w]),
      .wr_set_i       (set_idx),
      .wr_tag_i       (req_tag),
      .wr_dirty_i     (wr_dirty),
      .clr_valid_i    (invalidate_i || restart_i),
      .clr_dirty_en_i (flush_busy_q),
      .clr_dirty_set_i(flush_set_q)
    );
    assign hit_vec[w]   = rd_valid[w] && (rd_tag[w] == req_tag);
    assign wr_en_vec[w] = acc && (sel_way == WAY_W'(w));
  end

  free_way_pick #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_free (
    .valid_i   (rd_valid),
    .any_free_o(any_free),
    .free_way_o(free_way)
  );

  plru_tree #(
    .NUM_SETS(NUM_SETS), .SET_W(SET_W), .NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)
  ) u_plru (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (restart_i),
    .rd_set_i (set_idx),
    .victim_o (victim_way),
    .upd_en_i (acc),
    .upd_set_i(set_idx),
    .upd_way_i(sel_way)
  );

  always_comb begin
    hit     = |hit_vec;
    hit_way = '0;
    for (int w = 0; w < NUM_WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  always_comb begin
    if (hit) begin
      sel_way  = hit_way;
      code     = RSP_HIT;
      wr_dirty = rd_dirty[hit_way] | store;
    end else if (any_free) begin
      sel_way  = free_way;
      code     = RSP_FILL;
      wr_dirty = store;
    end else begin
      sel_way  = victim_way;
      code     = rd_dirty[victim_way] ? RSP_EVDRT : RSP_EVCLN;
      wr_dirty = store;
    end
  end

  // flush walker: one set per cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flush_busy_q <= 1'b0;
      flush_set_q  <= '0;
      flush_done_q <= 1'b0;
    end else begin
      flush_done_q <= 1'b0;
      if (flush_busy_q) begin
        if (flush_set_q == LAST_SET) begin
          flush_busy_q <= 1'b0;
          flush_done_q <= 1'b1;
        end
        flush_set_q <= flush_set_q + SET_W'(1);
      end else if (flush_i) begin
        flush_busy_q <= 1'b1;
        flush_set_q  <= '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_code_q  <= '0;
      rsp_way_q   <= '0;
    end else begin
      rsp_valid_q <= acc;
      if (acc) begin
        rsp_code_q <= code;
        rsp_way_q  <= sel_way;
      end
    end
  end

  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_code_o   = rsp_code_q;
  assign rsp_way_o    = rsp_way_q;
  assign flush_done_o = flush_done_q;
endmodule

// File: rtl/cache_tag_ctrl_chk.sv
module cache_tag_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_i,
  input logic req_ready_o,
  input logic rsp_valid_o,
  input logic flush_busy_i,
  input logic flush_done_o
);
  // R2
  rsp_follows_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> rsp_valid_o);

  // R2
  no_rsp_without_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_ready_o) |=> !rsp_valid_o);

  // R10
  stall_during_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_busy_i |-> !req_ready_o);

  // R9
  done_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_done_o |=> !flush_done_o);

  // R9
  done_at_walk_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flush_busy_i) |-> flush_done_o);

  // R9
  done_only_after_walk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_done_o |-> $past(flush_busy_i));
endmodule

bind cache_tag_ctrl cache_tag_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .flush_busy_i(flush_busy_q),
  .flush_done_o(flush_done_o)
);

// File: tb/cache_tag_ctrl_bench.sv
module cache_tag_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSETS = 16;
  localparam int NWAYS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic [1:0]  req_type = '0;
  logic        inv = 1'b0, rst_run = 1'b0, flush = 1'b0;
  logic        flush_done, rsp_valid;
  logic [1:0]  rsp_code, rsp_way;

  int total = 0;
  int bad = 0;

  // model state
  bit       m_valid [NSETS][NWAYS];
  bit       m_dirty [NSETS][NWAYS];
  bit [7:0] m_tag   [NSETS][NWAYS];
  bit [2:0] m_tree  [NSETS];  // [0]=root, [1]=ways 0/1 node, [2]=ways 2/3 node

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_tag_ctrl u_cache_tag_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_type_i(req_type),
    .invalidate_i(inv), .restart_i(rst_run), .flush_i(flush),
    .flush_done_o(flush_done),
    .rsp_valid_o(rsp_valid), .rsp_code_o(rsp_code), .rsp_way_o(rsp_way)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int tree_victim(input bit [2:0] b);
    return b[0] ? (b[2] ? 3 : 2) : (b[1] ? 1 : 0);
  endfunction

  function automatic bit [2:0] tree_touch(input bit [2:0] b, input int w);
    bit [2:0] n = b;
    n[0] = (w < 2);
    if (w < 2) n[1] = (w == 0);
    else       n[2] = (w == 2);
    return n;
  endfunction

  task automatic model_access(input logic [15:0] a, input logic [1:0] t,
                              output int code, output int way);
    int s = int'(a[7:4]);
    bit [7:0] tg = a[15:8];
    bit st = (t == 2'b01) || (t == 2'b10);
    way = -1;
    for (int w = 0; w < NWAYS; w++)
      if (m_valid[s][w] && m_tag[s][w] == tg) way = w;
    if (way >= 0) begin
      code = 0;
      m_dirty[s][way] = m_dirty[s][way] | st;
    end else begin
      for (int w = NWAYS - 1; w >= 0; w--)
        if (!m_valid[s][w]) way = w;
      if (way >= 0) code = 1;
      else begin
        way  = tree_victim(m_tree[s]);
        code = m_dirty[s][way] ? 3 : 2;
      end
      m_valid[s][way] = 1'b1;
      m_tag[s][way]   = tg;
      m_dirty[s][way] = st;
    end
    m_tree[s] = tree_touch(m_tree[s], way);
  endtask

  // called just after a negedge; returns just after the next one
  task automatic do_access(input logic [15:0] a, input logic [1:0] t, input string lbl);
    int ec, ew;
    string rc, rw;
    model_access(a, t, ec, ew);
    req_valid = 1'b1; req_addr = a; req_type = t;
    #1;
    chk(req_ready === 1'b1, "R10", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    rc = (lbl != "") ? lbl : (ec == 0) ? "R2" : (ec == 1) ? "R3" : "R5";
    rw = (lbl != "") ? lbl : (ec >= 2) ? "R6" : "R3";
    chk(rsp_valid === 1'b1, "R2", int'(rsp_valid), 1);
    chk(rsp_code === 2'(ec), rc, int'(rsp_code), ec);
    chk(rsp_way === 2'(ew), rw, int'(rsp_way), ew);
  endtask

  task automatic do_inv();
    inv = 1'b1;
    #1;
    chk(req_ready === 1'b0, "R10", int'(req_ready), 0);
    @(negedge clk);
    inv = 1'b0;
    for (int s = 0; s < NSETS; s++) for (int w = 0; w < NWAYS; w++) m_valid[s][w] = 0;
  endtask

  task automatic do_restart();
    rst_run = 1'b1;
    @(negedge clk);
    rst_run = 1'b0;
    for (int s = 0; s < NSETS; s++) begin
      m_tree[s] = '0;
      for (int w = 0; w < NWAYS; w++) m_valid[s][w] = 0;
    end
  endtask

  task automatic do_flush();
    int n = 1;
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    chk(req_ready === 1'b0, "R10", int'(req_ready), 0);
    while (flush_done !== 1'b1 && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(n == NSETS + 1, "R9", n, NSETS + 1);
    @(negedge clk);
    chk(flush_done === 1'b0, "R9", int'(flush_done), 0);
    for (int s = 0; s < NSETS; s++) for (int w = 0; w < NWAYS; w++) m_dirty[s][w] = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd5171));
    for (int s = 0; s < NSETS; s++) begin
      m_tree[s] = '0;
      for (int w = 0; w < NWAYS; w++) begin
        m_valid[s][w] = 0; m_dirty[s][w] = 0; m_tag[s][w] = '0;
      end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(req_ready === 1'b1, "R11", int'(req_ready), 1);
    chk(rsp_valid === 1'b0, "R11", int'(rsp_valid), 0);
    chk(flush_done === 1'b0, "R11", int'(flush_done), 0);

    // R1 address split, offset ignored
    do_access(16'h1234, 2'b00, "R1");
    do_access(16'h123F, 2'b00, "R1");
    do_access(16'h2634, 2'b00, "R1");
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R2", int'(rsp_valid), 0);

    // R3 R5 R6 fill order, tree walk and eviction kinds in set 0xC
    do_access(16'hABCD, 2'b00, "R3");
    do_access(16'hABCD, 2'b00, "R2");
    do_access(16'hABC0, 2'b01, "R4");
    do_access(16'hACCD, 2'b00, "R3");
    do_access(16'hADCD, 2'b00, "R3");
    do_access(16'hAECD, 2'b00, "R3");
    do_access(16'hABCD, 2'b00, "R6");
    do_access(16'hADCD, 2'b00, "R6");
    do_access(16'hAFCD, 2'b00, "R6");
    do_access(16'hACCD, 2'b00, "R6");
    do_access(16'hEAC2, 2'b00, "R5");

    // R4 type effects on dirty: read, write, atomic, reserved into set 5
    do_access(16'h0150, 2'b00, "R4");
    do_access(16'h0250, 2'b01, "R4");
    do_access(16'h0350, 2'b10, "R4");
    do_access(16'h0450, 2'b11, "R4");
    for (int k = 5; k < 9; k++) do_access({8'(k), 8'h50}, 2'b00, "R4");

    // R9 flush keeps lines valid but clean
    do_access(16'h0760, 2'b01, "R9");
    do_flush();
    do_access(16'h0760, 2'b00, "R9");
    for (int k = 8; k < 12; k++) do_access({8'(k), 8'h60}, 2'b00, "R9");

    // R7 invalidate keeps tree, R8 restart clears it
    do_access(16'h1170, 2'b00, "R7");
    do_access(16'h1270, 2'b00, "R7");
    do_inv();
    do_access(16'h1170, 2'b00, "R7");
    for (int k = 0; k < 4; k++) do_access({8'(8'h20 + k), 8'h70}, 2'b00, "R7");
    do_restart();
    for (int k = 0; k < 5; k++) do_access({8'(8'h30 + k), 8'h70}, 2'b01, "R8");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom % 100);
      if (r < 2) do_inv();
      else if (r < 3) do_restart();
      else if (r < 5) do_flush();
      else begin
        logic [15:0] a;
        a = {8'($urandom % 6), 4'($urandom), 4'($urandom)};
        do_access(a, 2'($urandom), "");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule